// File: doc/BRIEF.md
# Accumulator Output Saturation Unit

This block sits between a DSP multiply-accumulate datapath and the accumulator write port. Each result is 36 bits wide: a 4-bit extension field above a 16-bit high word and a 16-bit low word. When saturation mode is on, the block clamps results that have left the 32-bit signed range to the largest positive or negative 32-bit value, kept sign-extended into the extension field. Mode is off after reset. The overflow test looks at just three bits of the result: the top extension bit, the lowest extension bit and the sign bit of the high word.

The surrounding decoder marks operations that must never be clamped: shifts, rotates, bitwise logic and mixed signed-by-unsigned multiplies. It does this through a one-bit exempt input. When that input is high, the block acts as if mode were off. The pre-saturation condition flags (negative, carry, extension) travel beside the result unchanged, so they describe the unclamped value. A result accepted on a valid strobe comes out one cycle later. A one-cycle pulse marks every result whose value was changed.

Top module: `acc_sat_unit`

## Requirements
- R1: Asynchronous active-low reset clears the mode bit, `out_valid`, `out_sat`, the output result and the output flags to zero.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. Each accepted sample appears on the outputs one cycle after the edge that took it.
- R3: With mode on and exempt low, a result whose key bits {ext[3], ext[0], msw[15]} are 000 or 111 is output unchanged.
- R4: With mode on and exempt low, a result with ext[3]=0 and any other key bit at 1 is output as 0x0_7FFF_FFFF (ext=0x0, msw=0x7FFF, lsw=0xFFFF).
- R5: With mode on and exempt low, a result with ext[3]=1 and any other key bit at 0 is output as 0xF_8000_0000 (ext=0xF, msw=0x8000, lsw=0x0000).
- R6: With mode off, every accepted result is output unchanged and `out_sat` stays low.
- R7: With `in_exempt` high, the accepted result is output unchanged and `out_sat` stays low, whatever the mode.
- R8: The 3-bit flags (bit 2 negative, bit 1 carry, bit 0 extension) leave the block equal to the flags that came with the sample. They are never recomputed after clamping.
- R9: `out_sat` is high for the one cycle an accepted sample is presented, exactly when the output value differs from the input value. It is low whenever `out_valid` is low.
- R10: A mode write (`mode_we` high at an edge) loads `mode_wdata`. A sample taken at that same edge still uses the old mode, and the new mode applies from the next edge. Without `mode_we`, the mode is held.
- R11: While `in_valid` is low, the output result and flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the saturation-mode bit |
| mode_wdata | input | 1 | New value of the saturation-mode bit |
| in_valid | input | 1 | Accept the input sample at this edge |
| in_exempt | input | 1 | Operation is exempt from saturation |
| in_ext | input | 4 | Extension field of the raw result |
| in_msw | input | 16 | High word of the raw result |
| in_lsw | input | 16 | Low word of the raw result |
| in_flags | input | 3 | Pre-saturation condition flags {N, C, E} |
| out_valid | output | 1 | Output sample valid |
| out_ext | output | 4 | Extension field of the result to store |
| out_msw | output | 16 | High word of the result to store |
| out_lsw | output | 16 | Low word of the result to store |
| out_flags | output | 3 | Flags passed through from the input |
| out_sat | output | 1 | The stored value differs from the raw result |

## Verification
The bench builds the block with its default widths: a 4-bit extension, 16-bit words and 3 flags. With these widths all eight combinations of the three key bits can be driven directly, and the two limit words can be compared bit for bit against fixed constants. It also includes values that sit just inside the limits, such as 0x0_7FFF_FFFF and 0xF_8000_0000 themselves. A random phase mixes mode writes, exempt operations and idle cycles, so the same-edge mode-write ordering and output holding are exercised along with the clamping table.

// File: rtl/sat_pkg.sv
package sat_pkg;

   // Decision taken by the overflow detector for one sample.
   typedef enum logic [1:0] {
      SAT_KEEP = 2'd0,
      SAT_POS  = 2'd1,
      SAT_NEG  = 2'd2
   } sat_dec_e;

endpackage

// File: rtl/sat_mode_reg.sv
module sat_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_data,
   output logic mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= 1'b0;
      else if (wr_en) mode_q <= wr_data;
   end

   // R10: a write lands on the next edge; otherwise the bit holds
   a_r10_mode_write : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mode_q == $past(wr_data));
   a_r10_mode_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/sat_detect.sv
module sat_detect
   import sat_pkg::*;
(
   input  logic     enable,
   input  logic     ext_top,
   input  logic     ext_low,
   input  logic     msw_sign,
   output sat_dec_e dec
);

   logic agree;

   always_comb begin
      agree = (ext_top == ext_low) && (ext_low == msw_sign);
      if (!enable || agree) dec = SAT_KEEP;
      else if (!ext_top)    dec = SAT_POS;
      else                  dec = SAT_NEG;
   end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
   import sat_pkg::*;
#(
   parameter int EXT_W = 4,
   parameter int MSW_W = 16,
   parameter int LSW_W = 16
) (
   input  sat_dec_e           dec,
   input  logic [EXT_W-1:0]   raw_ext,
   input  logic [MSW_W-1:0]   raw_msw,
   input  logic [LSW_W-1:0]   raw_lsw,
   output logic [EXT_W-1:0]   sat_ext,
   output logic [MSW_W-1:0]   sat_msw,
   output logic [LSW_W-1:0]   sat_lsw
);

   localparam logic [EXT_W-1:0] POS_EXT = '0;
   localparam logic [MSW_W-1:0] POS_MSW = {1'b0, {(MSW_W-1){1'b1}}};
   localparam logic [LSW_W-1:0] POS_LSW = '1;
   localparam logic [EXT_W-1:0] NEG_EXT = '1;
   localparam logic [MSW_W-1:0] NEG_MSW = {1'b1, {(MSW_W-1){1'b0}}};
   localparam logic [LSW_W-1:0] NEG_LSW = '0;

   always_comb begin
      unique case (dec)
         SAT_POS: begin
            sat_ext = POS_EXT; sat_msw = POS_MSW; sat_lsw = POS_LSW;
         end
         SAT_NEG: begin
            sat_ext = NEG_EXT; sat_msw = NEG_MSW; sat_lsw = NEG_LSW;
         end
         default: begin
            sat_ext = raw_ext; sat_msw = raw_msw; sat_lsw = raw_lsw;
         end
      endcase
   end

endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit
   import sat_pkg::*;
#(
   parameter int EXT_W  = 4,
   parameter int MSW_W  = 16,
   parameter int LSW_W  = 16,
   parameter int FLAG_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic              mode_wdata,
   input  logic              in_valid,
   input  logic              in_exempt,
   input  logic [EXT_W-1:0]  in_ext,
   input  logic [MSW_W-1:0]  in_msw,
   input  logic [LSW_W-1:0]  in_lsw,
   input  logic [FLAG_W-1:0] in_flags,
   output logic              out_valid,
   output logic [EXT_W-1:0]  out_ext,
   output logic [MSW_W-1:0]  out_msw,
   output logic [LSW_W-1:0]  out_lsw,
   output logic [FLAG_W-1:0] out_flags,
   output logic              out_sat
);

   localparam int RES_W = EXT_W + MSW_W + LSW_W;
   localparam logic [RES_W-1:0] POS_LIM = {{EXT_W{1'b0}}, 1'b0, {(MSW_W+LSW_W-1){1'b1}}};
   localparam logic [RES_W-1:0] NEG_LIM = {{EXT_W{1'b1}}, 1'b1, {(MSW_W+LSW_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (EXT_W < 2) begin : g_bad_ext
      $error("acc_sat_unit: EXT_W must be at least 2");
   end
   if (MSW_W < 2) begin : g_bad_msw
      $error("acc_sat_unit: MSW_W must be at least 2");
   end
   if (LSW_W < 1) begin : g_bad_lsw
      $error("acc_sat_unit: LSW_W must be at least 1");
   end
   if (FLAG_W < 1) begin : g_bad_flag
      $error("acc_sat_unit: FLAG_W must be at least 1");
   end

   logic             mode_q;
   sat_dec_e         dec;
   logic [EXT_W-1:0] c_ext;
   logic [MSW_W-1:0] c_msw;
   logic [LSW_W-1:0] c_lsw;
   logic             changed;

   sat_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_we),
      .wr_data (mode_wdata),
      .mode_q  (mode_q)
   );

   sat_detect u_det (
      .enable   (mode_q & ~in_exempt),
      .ext_top  (in_ext[EXT_W-1]),
      .ext_low  (in_ext[0]),
      .msw_sign (in_msw[MSW_W-1]),
      .dec      (dec)
   );

   sat_clamp #(.EXT_W(EXT_W), .MSW_W(MSW_W), .LSW_W(LSW_W)) u_clamp (
      .dec     (dec),
      .raw_ext (in_ext),
      .raw_msw (in_msw),
      .raw_lsw (in_lsw),
      .sat_ext (c_ext),
      .sat_msw (c_msw),
      .sat_lsw (c_lsw)
   );

   assign changed = ({c_ext, c_msw, c_lsw} != {in_ext, in_msw, in_lsw});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sat   <= 1'b0;
         out_ext   <= '0;
         out_msw   <= '0;
         out_lsw   <= '0;
         out_flags <= '0;
      end else begin
         out_valid <= in_valid;
         out_sat   <= in_valid & changed;
         if (in_valid) begin
            out_ext   <= c_ext;
            out_msw   <= c_msw;
            out_lsw   <= c_lsw;
            out_flags <= in_flags;
         end
      end
   end

   // R2: one-cycle latency of the valid strobe
   a_r2_valid_latency : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_sat);
   // R8: flags are carried, never recomputed
   a_r8_flags_pass : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_flags == $past(in_flags));
   // R6: mode off means untouched result
   a_r6_mode_off_pass : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !mode_q |=>
         !out_sat && {out_ext, out_msw, out_lsw} == $past({in_ext, in_msw, in_lsw}));
   // R7: exempt operations are untouched
   a_r7_exempt_pass : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_exempt |=>
         !out_sat && {out_ext, out_msw, out_lsw} == $past({in_ext, in_msw, in_lsw}));
   // R3: agreeing key bits never clamp
   a_r3_no_clamp : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_ext[EXT_W-1] == in_ext[0]) && (in_ext[0] == in_msw[MSW_W-1]) |=>
         !out_sat && {out_ext, out_msw, out_lsw} == $past({in_ext, in_msw, in_lsw}));
   // R9: a flagged change always lands on one of the two limits
   a_r9_sat_is_limit : assert property (@(posedge clk) disable iff (!rst_n)
      out_sat |-> ({out_ext, out_msw, out_lsw} == POS_LIM ||
                   {out_ext, out_msw, out_lsw} == NEG_LIM));
   // R11: idle cycles hold the stored result
   a_r11_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable({out_ext, out_msw, out_lsw, out_flags}));

endmodule

// File: tb/test_acc_sat_unit.sv
module test_acc_sat_unit;

   localparam int EXT_W = 4, MSW_W = 16, LSW_W = 16, FLAG_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_we = 1'b0, mode_wdata = 1'b0;
   logic in_valid = 1'b0, in_exempt = 1'b0;
   logic [3:0]  in_ext = '0;
   logic [15:0] in_msw = '0, in_lsw = '0;
   logic [2:0]  in_flags = '0;
   logic out_valid, out_sat;
   logic [3:0]  out_ext;
   logic [15:0] out_msw, out_lsw;
   logic [2:0]  out_flags;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // reference state
   bit        m_mode = 0;
   bit        e_val = 0, e_sat = 0;
   bit [35:0] e_res = '0;
   bit [2:0]  e_flags = '0;

   always #2 clk = ~clk;

   acc_sat_unit #(.EXT_W(EXT_W), .MSW_W(MSW_W), .LSW_W(LSW_W), .FLAG_W(FLAG_W))
   i_acc_sat_unit (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .in_valid(in_valid), .in_exempt(in_exempt), .in_ext(in_ext), .in_msw(in_msw),
      .in_lsw(in_lsw), .in_flags(in_flags), .out_valid(out_valid), .out_ext(out_ext),
      .out_msw(out_msw), .out_lsw(out_lsw), .out_flags(out_flags), .out_sat(out_sat)
   );

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   task automatic compare(input string tag);
      bit [35:0] got;
      got = {out_ext, out_msw, out_lsw};
      total++;
      if (out_valid !== e_val || out_sat !== e_sat || got !== e_res || out_flags !== e_flags) begin
         bad++;
         $display("FAIL %s: actual v=%b s=%b res=%h f=%b expected v=%b s=%b res=%h f=%b",
                  tag, out_valid, out_sat, got, out_flags, e_val, e_sat, e_res, e_flags);
      end
   endtask

   // drive one cycle, advance the model over the edge, compare at negedge
   task automatic cyc(input bit we, input bit wd, input bit v, input bit ex,
                      input bit [35:0] raw, input bit [2:0] fl, input string tag);
      bit [35:0] res;
      bit k3, k0, km;
      mode_we = we; mode_wdata = wd; in_valid = v; in_exempt = ex;
      {in_ext, in_msw, in_lsw} = raw; in_flags = fl;
      k3 = raw[35]; k0 = raw[32]; km = raw[31];
      res = raw;
      if (m_mode && !ex && !(k3 == k0 && k0 == km))
         res = k3 ? 36'hF_8000_0000 : 36'h0_7FFF_FFFF;
      @(posedge clk);
      e_val = v;
      e_sat = v && (res != raw);
      if (v) begin
         e_res = res; e_flags = fl;
      end
      if (we) m_mode = wd;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_mode = 0; e_val = 0; e_sat = 0; e_res = '0; e_flags = '0;
      repeat (2) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1: mode cleared after reset, overflow passes
      cyc(0, 0, 1, 0, 36'h1_2345_6789, 3'b101, "R1");
      // R6: mode off, several overflowing values untouched
      cyc(0, 0, 1, 0, 36'h0_8000_0000, 3'b011, "R6");
      cyc(0, 0, 1, 0, 36'hE_0000_0001, 3'b110, "R6");
      // R10: write with a sample on the same edge uses old mode
      cyc(1, 1, 1, 0, 36'h3_0000_0000, 3'b001, "R10");
      cyc(0, 0, 1, 0, 36'h3_0000_0000, 3'b001, "R10");
      // R3/R4/R5: all eight key patterns
      for (int k = 0; k < 8; k++) begin
         bit [35:0] r;
         r = 36'h0_1234_5678;
         r[35] = k[2]; r[32] = k[1]; r[31] = k[0];
         if (k == 0 || k == 7) cyc(0, 0, 1, 0, r, 3'(k), "R3");
         else if (k < 4)       cyc(0, 0, 1, 0, r, 3'(k), "R4");
         else                  cyc(0, 0, 1, 0, r, 3'(k), "R5");
      end
      // R3: values at the limits are unchanged
      cyc(0, 0, 1, 0, 36'h0_7FFF_FFFF, 3'b000, "R3");
      cyc(0, 0, 1, 0, 36'hF_8000_0000, 3'b100, "R3");
      // R8: flags from an overflowed sample stay unclamped-view
      cyc(0, 0, 1, 0, 36'h7_FFFF_0000, 3'b010, "R8");
      // R7: exempt overrides mode
      cyc(0, 0, 1, 1, 36'h0_8000_0000, 3'b111, "R7");
      cyc(0, 0, 1, 1, 36'h9_0000_0000, 3'b100, "R7");
      // R11/R9: idle holds result, sat drops
      cyc(0, 0, 0, 0, 36'h5_5555_5555, 3'b111, "R11");
      cyc(0, 0, 0, 0, 36'hA_AAAA_AAAA, 3'b000, "R9");
      // R10: clear mode, hold without write
      cyc(1, 0, 0, 0, 36'h0, 3'b000, "R10");
      cyc(0, 1, 1, 0, 36'h2_0000_0000, 3'b001, "R10");
      // R2: mixed random traffic
      for (int i = 0; i < 400; i++) begin
         bit [35:0] r;
         r = {4'($urandom), 32'($urandom)};
         cyc(($urandom % 5) == 0, 1'($urandom), ($urandom % 4) != 0,
             ($urandom % 6) == 0, r, 3'($urandom), "R2");
      end
      // R1: reset again mid-run with mode on
      cyc(1, 1, 0, 0, 36'h0, 3'b000, "R10");
      do_reset();
      cyc(0, 0, 1, 0, 36'h4_0000_0000, 3'b010, "R1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule